// File: doc/BRIEF.md
# Dual-Enable Static Memory Array

This block is a 256-word by 4-bit static memory. It is modelled as a clocked stand-in for an asynchronous static RAM. Data enters and leaves on separate 4-bit buses and an 8-bit address picks the word. On every rising clock edge the block samples five controls. Two chip selects of opposite polarity must both be active for the array to respond. A read/write select and an output-disable input then pick one of four modes: idle, muted read, write or read.

The three-state data pin of an asynchronous part is shown here as a 4-bit bus plus a drive-enable flag. While the flag is low the bus is held at zero. The output flag and data are registered, so they reflect the controls sampled one edge earlier. The array has no reset and needs no refresh. Its contents survive any number of idle cycles and also survive the output reset.

Top module: `sram_dual_en`

## Requirements
- R1: While `rst_ni` is low, and on the first edge after it rises with the block idle, `dout_en_o` is 0 and `dout_o` is 4'h0.
- R2: An edge that samples `sel_n_i` = 1 writes nothing and leaves `dout_en_o` = 0 after that edge, whatever the other inputs are.
- R3: An edge that samples `sel_i` = 0 writes nothing and leaves `dout_en_o` = 0 after that edge, whatever the other inputs are.
- R4: An edge that samples the block selected with `read_i` = 1 and `hold_out_i` = 1 leaves `dout_en_o` = 0 and changes no stored word.
- R5: An edge that samples the block selected with `read_i` = 0 stores `din_i` at `addr_i`. If `hold_out_i` = 1 on that edge, `dout_en_o` is 0 afterwards.
- R6: An edge that samples a write with `hold_out_i` = 0 sets `dout_en_o` = 1 and `dout_o` to the `din_i` being written. This is write-through.
- R7: An edge that samples the block selected with `read_i` = 1 and `hold_out_i` = 0 sets `dout_en_o` = 1 and `dout_o` to the word stored at `addr_i`.
- R8: A read on the edge right after a write to the same address returns the newly written data.
- R9: Stored words keep their values across any number of deselected cycles and across an assertion of `rst_ni`.
- R10: Whenever `dout_en_o` is 0, `dout_o` is 4'h0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register only |
| addr_i | input | 8 | Word address |
| din_i | input | 4 | Write data |
| sel_n_i | input | 1 | Active-low chip select |
| sel_i | input | 1 | Active-high chip select |
| hold_out_i | input | 1 | Output disable, 1 = output not driven |
| read_i | input | 1 | 1 = read, 0 = write |
| dout_o | output | 4 | Read or write-through data, zero when not driven |
| dout_en_o | output | 1 | Output drive enable, stands in for the three-state control |

## Verification
A mis-decoded mode shows on `dout_en_o` exactly one edge after the offending controls are sampled. A wrong drive decision is therefore caught at the next sample point. A corrupted or wrongly addressed stored word stays invisible until that address is read. It then appears on `dout_o` one edge after the read. For this reason the bench fills every address, reads every address back, and re-reads words after deselected, muted and reset periods. A write that leaks through while the block is deselected is exposed by re-reading the targeted word.

// File: rtl/sram_pkg.sv
package sram_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_MUTE  = 2'd1,
    MODE_WRITE = 2'd2,
    MODE_READ  = 2'd3
  } access_mode_e;

endpackage

// File: rtl/sram_mode_dec.sv
module sram_mode_dec
  import sram_pkg::*;
(
  input  logic         sel_n_i,
  input  logic         sel_i,
  input  logic         hold_out_i,
  input  logic         read_i,
  output access_mode_e mode_o,
  output logic         drive_o,
  output logic         we_o
);

  logic selected;

  assign selected = !sel_n_i && sel_i;

  always_comb begin
    if (!selected)      mode_o = MODE_IDLE;
    else if (!read_i)   mode_o = MODE_WRITE;
    else if (hold_out_i) mode_o = MODE_MUTE;
    else                mode_o = MODE_READ;
  end

  // write-through drives unless the output is disabled
  assign drive_o = (mode_o == MODE_READ) ||
                   ((mode_o == MODE_WRITE) && !hold_out_i);
  assign we_o    = (mode_o == MODE_WRITE);

endmodule

// File: rtl/sram_store.sv
module sram_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  // one bit column per data bit; no reset, contents undefined at power-up
  for (genvar b = 0; b < DATA_W; b++) begin : g_col
    logic [DEPTH-1:0] col_q;

    always_ff @(posedge clk_i) begin
      if (we_i) col_q[addr_i] <= wdata_i[b];
    end

    assign rdata_o[b] = col_q[addr_i];
  end

endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
  import sram_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  access_mode_e      mode_i,
  input  logic              drive_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_en_o
);

  logic [DATA_W-1:0] dout_d;

  always_comb begin
    dout_d = '0;
    if (drive_i) dout_d = (mode_i == MODE_WRITE) ? wdata_i : rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_o    <= '0;
      dout_en_o <= 1'b0;
    end else begin
      dout_o    <= dout_d;
      dout_en_o <= drive_i;
    end
  end

endmodule

// File: rtl/sram_dual_en.sv
module sram_dual_en
  import sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              sel_n_i,
  input  logic              sel_i,
  input  logic              hold_out_i,
  input  logic              read_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_en_o
);

  access_mode_e      mode;
  logic              drive;
  logic              we;
  logic [DATA_W-1:0] rdata;

  sram_mode_dec u_dec (
    .sel_n_i    (sel_n_i),
    .sel_i      (sel_i),
    .hold_out_i (hold_out_i),
    .read_i     (read_i),
    .mode_o     (mode),
    .drive_o    (drive),
    .we_o       (we)
  );

  sram_store #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_store (
    .clk_i   (clk_i),
    .we_i    (we),
    .addr_i  (addr_i),
    .wdata_i (din_i),
    .rdata_o (rdata)
  );

  sram_out_stage #(
    .DATA_W (DATA_W)
  ) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .drive_i   (drive),
    .wdata_i   (din_i),
    .rdata_i   (rdata),
    .dout_o    (dout_o),
    .dout_en_o (dout_en_o)
  );

endmodule

// File: rtl/sram_dual_en_chk.sv
module sram_dual_en_chk #(
  parameter int DATA_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] din_i,
  input logic              sel_n_i,
  input logic              sel_i,
  input logic              hold_out_i,
  input logic              read_i,
  input logic [DATA_W-1:0] dout_o,
  input logic              dout_en_o
);

  a_r2_low_sel_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_n_i |=> !dout_en_o);

  a_r3_high_sel_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> !dout_en_o);

  a_r4_muted_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_n_i && sel_i && read_i && hold_out_i) |=> !dout_en_o);

  a_r5_muted_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_n_i && sel_i && !read_i && hold_out_i) |=> !dout_en_o);

  a_r6_write_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_n_i && sel_i && !read_i && !hold_out_i)
      |=> (dout_en_o && dout_o == $past(din_i)));

  a_r7_read_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_n_i && sel_i && read_i && !hold_out_i) |=> dout_en_o);

  a_r10_zero_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dout_en_o |-> (dout_o == '0));

endmodule

bind sram_dual_en sram_dual_en_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .din_i      (din_i),
  .sel_n_i    (sel_n_i),
  .sel_i      (sel_i),
  .hold_out_i (hold_out_i),
  .read_i     (read_i),
  .dout_o     (dout_o),
  .dout_en_o  (dout_en_o)
);

// File: tb/tb_sram_dual_en.sv
module tb_sram_dual_en;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] addr_i = '0;
  logic [3:0] din_i = '0;
  logic       sel_n_i = 1'b1;
  logic       sel_i = 1'b0;
  logic       hold_out_i = 1'b1;
  logic       read_i = 1'b1;
  logic [3:0] dout_o;
  logic       dout_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [3:0] exp_mem [256];

  always #4 clk_i = ~clk_i;

  sram_dual_en dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .din_i      (din_i),
    .sel_n_i    (sel_n_i),
    .sel_i      (sel_i),
    .hold_out_i (hold_out_i),
    .read_i     (read_i),
    .dout_o     (dout_o),
    .dout_en_o  (dout_en_o)
  );

  function automatic logic [3:0] pat(input int a);
    logic [7:0] v;
    v = a[7:0];
    return v[3:0] ^ v[7:4] ^ 4'h5;
  endfunction

  task automatic check(input string req, input logic en_exp, input logic [3:0] d_exp);
    checks++;
    if (dout_en_o !== en_exp || dout_o !== d_exp) begin
      errors++;
      $display("FAIL %s: got en=%b data=%h, expected en=%b data=%h",
               req, dout_en_o, dout_o, en_exp, d_exp);
    end
  endtask

  // drive at negedge, let one rising edge sample, return at next negedge
  task automatic cyc(input logic sn, input logic s, input logic h, input logic rd,
                     input logic [7:0] a, input logic [3:0] d);
    sel_n_i = sn; sel_i = s; hold_out_i = h; read_i = rd; addr_i = a; din_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 4'h0);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    check("R1 in reset", 1'b0, 4'h0);
    rst_ni = 1'b1;
    idle(1);
    check("R1 after release", 1'b0, 4'h0);
  endtask

  task automatic t_fill_and_read();
    for (int a = 0; a < 256; a++) begin
      cyc(1'b0, 1'b1, 1'b1, 1'b0, a[7:0], pat(a));
      exp_mem[a] = pat(a);
      check("R5 muted write", 1'b0, 4'h0);
    end
    for (int a = 0; a < 256; a++) begin
      cyc(1'b0, 1'b1, 1'b0, 1'b1, a[7:0], 4'h0);
      check("R7 read", 1'b1, exp_mem[a]);
    end
  endtask

  task automatic t_write_through();
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'h3c, 4'ha);
    exp_mem[8'h3c] = 4'ha;
    check("R6 write-through", 1'b1, 4'ha);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'h3d, 4'h0);
    exp_mem[8'h3d] = 4'h0;
    check("R6 write-through zero", 1'b1, 4'h0);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 8'h3c, 4'h0);
    check("R5 stored by write-through", 1'b1, 4'ha);
  endtask

  task automatic t_back_to_back();
    for (int k = 0; k < 4; k++) begin
      logic [7:0] a;
      logic [3:0] d;
      a = 8'h80 + 8'(k * 17);
      d = ~exp_mem[a];
      cyc(1'b0, 1'b1, 1'b1, 1'b0, a, d);
      exp_mem[a] = d;
      cyc(1'b0, 1'b1, 1'b0, 1'b1, a, 4'h0);
      check("R8 read after write", 1'b1, d);
    end
  endtask

  task automatic t_deselect();
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h10, ~exp_mem[8'h10]);
    check("R2 low-select off", 1'b0, 4'h0);
    check("R10 zero when off", dout_en_o, 4'h0);
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 8'h10, 4'h0);
    check("R2 read blocked", 1'b0, 4'h0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'h11, ~exp_mem[8'h11]);
    check("R3 high-select off", 1'b0, 4'h0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'h11, 4'h0);
    check("R3 read blocked", 1'b0, 4'h0);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 8'h10, 4'h0);
    check("R2 no write while deselected", 1'b1, exp_mem[8'h10]);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 8'h11, 4'h0);
    check("R3 no write while deselected", 1'b1, exp_mem[8'h11]);
  endtask

  task automatic t_out_disable();
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 8'h22, ~exp_mem[8'h22]);
    check("R4 muted read", 1'b0, 4'h0);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 8'h22, 4'h0);
    check("R4 word unchanged", 1'b1, exp_mem[8'h22]);
  endtask

  task automatic t_retain();
    idle(100);
    check("R9 idle output", 1'b0, 4'h0);
    rst_ni = 1'b0;
    idle(3);
    check("R1 reset again", 1'b0, 4'h0);
    rst_ni = 1'b1;
    for (int a = 0; a < 256; a += 15) begin
      cyc(1'b0, 1'b1, 1'b0, 1'b1, a[7:0], 4'h0);
      check("R9 retained", 1'b1, exp_mem[a]);
    end
  endtask

  initial begin
    t_reset();
    t_fill_and_read();
    t_write_through();
    t_back_to_back();
    t_deselect();
    t_out_disable();
    t_retain();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule